// File: doc/BRIEF.md
# One-time-enabled watchdog timer

This block is a watchdog for a small microcontroller core. It stays dormant after a hardware reset until software writes two key bytes, 0x1E followed by 0xE1, to one service register address. From then on it counts machine-cycle ticks, and software cannot turn it off. Software must repeat the same two-byte pair often enough to restart the count. If the count runs out, the block raises an active-high reset-out pulse of fixed length on the oscillator clock. After that pulse the watchdog is dormant again.

Counting freezes while the core is in power-down, because the oscillator is stopped. A configuration input decides whether counting carries on or pauses in idle. A second configuration input masks the reset-out pin, while the overflow still takes effect inside the block. The count itself cannot be read or written by software.

Top module: `lock_wdt`

## Requirements
- R1: After a hardware reset (rst_ni low) the watchdog is disabled, its count and the key tracker are cleared, and wdt_rst_o is low at once. An unfinished key sequence started before the reset has no effect after it, and a pulse in progress ends.
- R2: Two accepted writes to address SVC_ADDR (default 0xA6) enable the watchdog: data 0x1E, then data 0xE1. Writes to any other address, and cycles with wr_en_i low, are ignored and do not break an unfinished sequence.
- R3: After a 0x1E write, any other data written to SVC_ADDR discards the sequence, and that write does not start a new one. As a result, 0x1E,0x1E,0xE1 has no effect, and 0xE1 without a preceding 0x1E has no effect.
- R4: Once enabled, the watchdog counts effective ticks. Overflow happens on effective tick number 2^CNT_W-1 (16383 by default) after enabling. wdt_rst_o rises in the clock cycle right after the edge that takes that tick.
- R5: While the watchdog is enabled, the 0x1E,0xE1 pair restarts the count. The next overflow then comes after a full 2^CNT_W-1 effective ticks counted from the 0xE1 write.
- R6: The reset-out pulse lasts exactly PULSE_LEN clock cycles (96 by default), whatever tick_i does.
- R7: No write other than the complete key pair changes the count or disables the watchdog. After an overflow the watchdog is disabled, and it gives no further pulse until it is enabled again.
- R8: While pdown_i is 1, tick_i is ignored and the count holds.
- R9: With idle_hold_i at 0, ticks are counted while idle_i is 1. With idle_hold_i at 1, ticks are ignored while idle_i is 1.
- R10: While rst_out_dis_i is 1, wdt_rst_o stays low. An overflow still disables the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 8 | Write data |
| tick_i | input | 1 | One-cycle machine-cycle tick |
| idle_i | input | 1 | Core is in idle |
| pdown_i | input | 1 | Core is in power-down |
| idle_hold_i | input | 1 | 1 = pause counting in idle |
| rst_out_dis_i | input | 1 | 1 = mask the reset-out pin |
| wdt_rst_o | output | 1 | Active-high reset-out pulse |

## Verification
The count register is updated at the edge that accepts a tick. The overflow loads the pulse counter at that same edge, so wdt_rst_o is high from the next cycle and stays high for PULSE_LEN cycles. The enable or restart takes effect at the edge that accepts the 0xE1 write.

The bench drives every input just after a falling edge and samples wdt_rst_o at the falling edge before it drives. It counts only the ticks the requirements call effective, and it expects the rising edge on exactly the sample after the last of 2^CNT_W-1 such ticks. It then counts the high samples to measure the pulse width.

Patterns with no effect are checked by running past a full overflow window and confirming that no pulse appears. For those on an already enabled watchdog, the bench instead confirms that the pulse arrives after the unchanged remaining tick count.

// File: rtl/lock_wdt_pkg.sv
package lock_wdt_pkg;
  localparam int DATA_W = 8;
  typedef logic [DATA_W-1:0] wdt_byte_t;
  localparam wdt_byte_t KEY_ARM  = 8'h1E;
  localparam wdt_byte_t KEY_FIRE = 8'hE1;
endpackage

// File: rtl/lock_wdt_unlock.sv
module lock_wdt_unlock
  import lock_wdt_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 8'hA6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  wdt_byte_t         wr_data_i,
  output logic              key_ok_o
);
  logic hit;
  logic armed_q;

  assign hit      = wr_en_i && (wr_addr_i == SVC_ADDR);
  assign key_ok_o = hit && armed_q && (wr_data_i == KEY_FIRE);

  // the write that follows an arm always ends the sequence, whatever it is
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  armed_q <= 1'b0;
    else if (hit) armed_q <= !armed_q && (wr_data_i == KEY_ARM);
  end
endmodule

// File: rtl/lock_wdt_count.sv
module lock_wdt_count #(
  parameter int CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_ok_i,
  input  logic             adv_i,
  output logic             en_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}} - 1'b1;

  logic             en_q;
  logic [CNT_W-1:0] cnt_q;

  assign ovf_o = en_q && adv_i && (cnt_q == LAST);
  assign en_o  = en_q;
  assign cnt_o = cnt_q;

  // overflow beats a same-cycle restart; a restart beats an increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else if (ovf_o) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else if (key_ok_i) begin
      en_q  <= 1'b1;
      cnt_q <= '0;
    end else if (en_q && adv_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/lock_wdt_pulse.sv
module lock_wdt_pulse #(
  parameter int PULSE_LEN = 96
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_i,
  output logic active_o
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam logic [PW-1:0] LOAD = PW'(PULSE_LEN);

  logic [PW-1:0] left_q;

  assign active_o = (left_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       left_q <= '0;
    else if (ovf_i)    left_q <= LOAD;
    else if (active_o) left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/lock_wdt.sv
module lock_wdt
  import lock_wdt_pkg::*;
#(
  parameter int CNT_W     = 14,
  parameter int PULSE_LEN = 96,
  parameter int ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 8'hA6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              tick_i,
  input  logic              idle_i,
  input  logic              pdown_i,
  input  logic              idle_hold_i,
  input  logic              rst_out_dis_i,
  output logic              wdt_rst_o
);
  logic             key_ok;
  logic             adv;
  logic             en_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf;
  logic             pulse_act;

  // oscillator stopped in power-down; idle pause is optional
  assign adv = tick_i && !pdown_i && !(idle_i && idle_hold_i);

  lock_wdt_unlock #(.ADDR_W(ADDR_W), .SVC_ADDR(SVC_ADDR)) u_unlock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wdt_byte_t'(wr_data_i)),
    .key_ok_o  (key_ok)
  );

  lock_wdt_count #(.CNT_W(CNT_W)) u_count (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .key_ok_i (key_ok),
    .adv_i    (adv),
    .en_o     (en_q),
    .cnt_o    (cnt_q),
    .ovf_o    (ovf)
  );

  lock_wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ovf_i    (ovf),
    .active_o (pulse_act)
  );

  assign wdt_rst_o = pulse_act && !rst_out_dis_i;
endmodule

// File: rtl/lock_wdt_chk.sv
module lock_wdt_chk #(
  parameter int CNT_W     = 14,
  parameter int PULSE_LEN = 96
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pdown_i,
  input logic             idle_i,
  input logic             idle_hold_i,
  input logic             en_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             key_ok,
  input logic             ovf,
  input logic             pulse_act
);
  localparam int RW = $clog2(PULSE_LEN + 2);

  logic [RW-1:0] run_q;

  // consecutive prior cycles with the pulse active
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        run_q <= '0;
    else if (!pulse_act)                run_q <= '0;
    else if (run_q != {RW{1'b1}})       run_q <= run_q + 1'b1;
  end

  AST_IDLE_CNT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> cnt_q == '0);                                          // R1
  AST_OVF_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf |=> pulse_act && !en_q);                                     // R4
  AST_SVC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_ok && !ovf |=> en_q && cnt_q == '0);                         // R5
  AST_PULSE_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_act |-> run_q < RW'(PULSE_LEN));                           // R6
  AST_PULSE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_act) |-> $past(run_q) == RW'(PULSE_LEN - 1));        // R6
  AST_PDOWN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdown_i && !key_ok |=> $stable(cnt_q));                          // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i && idle_hold_i && !key_ok |=> $stable(cnt_q));            // R9
endmodule

bind lock_wdt lock_wdt_chk #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pdown_i     (pdown_i),
  .idle_i      (idle_i),
  .idle_hold_i (idle_hold_i),
  .en_q        (en_q),
  .cnt_q       (cnt_q),
  .key_ok      (key_ok),
  .ovf         (ovf),
  .pulse_act   (pulse_act)
);

// File: tb/lock_wdt_bench.sv
`timescale 1ns/1ps
module lock_wdt_bench;
  localparam int CNT_W = 6;
  localparam int PLEN  = 10;
  localparam int MAXT  = (1 << CNT_W) - 1;
  localparam logic [7:0] SVC = 8'hA6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 1'b0;
  logic [7:0] wr_addr_i = 8'h00;
  logic [7:0] wr_data_i = 8'h00;
  logic tick_i = 1'b0, idle_i = 1'b0, pdown_i = 1'b0;
  logic idle_hold_i = 1'b0, rst_out_dis_i = 1'b0;
  logic wdt_rst_o;

  int nchk = 0;
  int nfail = 0;

  always #10 clk_i = ~clk_i;

  lock_wdt #(.CNT_W(CNT_W), .PULSE_LEN(PLEN), .ADDR_W(8), .SVC_ADDR(SVC)) u_lock_wdt (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .tick_i(tick_i), .idle_i(idle_i), .pdown_i(pdown_i),
    .idle_hold_i(idle_hold_i), .rst_out_dis_i(rst_out_dis_i), .wdt_rst_o(wdt_rst_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    tick_i = 1'b0; wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    cyc();
    wr_en_i = 1'b0;
  endtask

  task automatic hw_reset();
    rst_ni = 1'b0;
    cyc(); cyc();
    rst_ni = 1'b1;
    cyc();
  endtask

  task automatic enable();
    wr(SVC, 8'h1E);
    wr(SVC, 8'hE1);
  endtask

  // n ticks, one per cycle; returns number of cycles wdt_rst_o was seen high
  task automatic run_n(input int n, output int highs);
    highs = 0;
    idle_i = 1'b0; pdown_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (wdt_rst_o) highs++;
      tick_i = 1'b1;
      cyc();
    end
    if (wdt_rst_o) highs++;
    tick_i = 1'b0;
  endtask

  // run a pattern until wdt_rst_o rises; count effective ticks, then pulse width
  task automatic run_to_rst(input int p, input int im, input int pm,
                            output int eff, output int width);
    int c;
    eff = 0; width = 0; c = 0;
    while (!wdt_rst_o && c < 20000) begin
      tick_i  = ((c % p) == 0);
      idle_i  = (im != 0) && (((c / 3) % 2) == 1);
      pdown_i = (pm != 0) && (((c / 5) % 3) == 0);
      if (tick_i && !pdown_i && !(idle_i && idle_hold_i)) eff++;
      cyc();
      c++;
    end
    idle_i = 1'b0; pdown_i = 1'b0;
    while (wdt_rst_o && width < 1000) begin
      width++;
      tick_i = ~tick_i;
      cyc();
    end
    tick_i = 1'b0;
  endtask

  initial begin
    #3000000;
    nfail++;
    $display("FAIL watchdog timeout act=1 exp=0");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    int h, e, w;
    @(negedge clk_i);
    hw_reset();
    chk("R1 reset output", int'(wdt_rst_o), 0);
    run_n(MAXT + 5, h);
    chk("R1 disabled after reset", h, 0);

    // R4 R6 R8 R9 sweep over tick rate, idle and power-down patterns
    for (int hold = 0; hold < 2; hold++)
      for (int p = 1; p <= 3; p++)
        for (int im = 0; im < 2; im++)
          for (int pm = 0; pm < 2; pm++) begin
            idle_hold_i = hold[0];
            enable();
            run_to_rst(p, im, pm, e, w);
            chk($sformatf("R4 R8 R9 ticks hold=%0d p=%0d i=%0d d=%0d", hold, p, im, pm), e, MAXT);
            chk("R6 pulse width", w, PLEN);
          end
    idle_hold_i = 1'b0;

    // R7 stopped after overflow
    run_n(MAXT + 5, h);
    chk("R7 no pulse after overflow", h, 0);

    // R5 restart at every count position
    for (int k = 0; k < MAXT; k++) begin
      enable();
      run_n(k, h);
      chk("R5 no early pulse", h, 0);
      enable();
      run_to_rst(1, 0, 0, e, w);
      chk($sformatf("R5 full window after service k=%0d", k), e, MAXT);
    end

    // R2 other addresses ignored and do not break the sequence
    wr(SVC, 8'h1E); wr(8'hA5, 8'hE1); wr(8'hA7, 8'h1E); wr(SVC, 8'hE1);
    run_to_rst(1, 0, 0, e, w);
    chk("R2 enable through foreign writes", e, MAXT);

    // R3 broken sequences while disabled
    wr(SVC, 8'hE1);
    run_n(MAXT + 5, h);
    chk("R3 lone E1", h, 0);
    wr(SVC, 8'h1E); wr(SVC, 8'h00); wr(SVC, 8'hE1);
    run_n(MAXT + 5, h);
    chk("R3 1E,00,E1", h, 0);
    wr(SVC, 8'h1E); wr(SVC, 8'h1E); wr(SVC, 8'hE1);
    run_n(MAXT + 5, h);
    chk("R3 1E,1E,E1", h, 0);

    // R3 R7 broken sequences while enabled leave the count untouched
    enable();
    run_n(10, h);
    wr(SVC, 8'h1E); wr(SVC, 8'h1E); wr(SVC, 8'hE1);
    run_to_rst(1, 0, 0, e, w);
    chk("R3 no service by 1E,1E,E1", e, MAXT - 10);
    enable();
    run_n(20, h);
    wr(SVC, 8'h00); wr(SVC, 8'hE1); wr(SVC, 8'h55); wr(8'h12, 8'h1E);
    run_to_rst(1, 0, 0, e, w);
    chk("R7 stray writes do not touch count", e, MAXT - 20);

    // R10 masked output, overflow still stops the watchdog
    rst_out_dis_i = 1'b1;
    enable();
    run_n(MAXT + PLEN + 5, h);
    chk("R10 output masked", h, 0);
    rst_out_dis_i = 1'b0;
    run_n(MAXT + 5, h);
    chk("R10 stopped by hidden overflow", h, 0);

    // R1 reset mid-count, with an armed tracker, and during a pulse
    enable();
    run_n(30, h);
    hw_reset();
    run_n(MAXT + 5, h);
    chk("R1 reset stops watchdog", h, 0);
    wr(SVC, 8'h1E);
    hw_reset();
    wr(SVC, 8'hE1);
    run_n(MAXT + 5, h);
    chk("R1 reset clears tracker", h, 0);
    enable();
    run_n(MAXT, h);
    chk("R4 pulse seen before reset", int'(wdt_rst_o), 1);
    cyc(); cyc();
    rst_ni = 1'b0;
    #1;
    chk("R1 reset ends pulse", int'(wdt_rst_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    cyc();
    chk("R1 low after reset release", int'(wdt_rst_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule